// File: doc/BRIEF.md
# Fractional Clock Divider with Update Trigger

This block turns a free-running clock into a stream of single-cycle clock-enable pulses whose average rate is the input rate divided by a fixed-point divisor. The divisor lives in a field of a 32-bit control register. The field holds the divisor minus one, expressed in units of 2^-FRAC_W input cycles. A field value of zero therefore divides by exactly one. A phase accumulator spreads the fractional remainder over successive periods, so the long-run rate is exact and no rounding error builds up.

Software stages a new divisor by writing the field, which on its own changes nothing. It then writes a 1 to the trigger bit. The block moves the staged value into the active divisor only at the end of an output period. In that same cycle it restarts the accumulator and clears the trigger bit, so software can poll that bit to learn that the switch has happened. Register writes carry a bit mask, and bits outside the mask keep their value. A build-time option replaces the programmable divisor with a constant. In that build the divisor field reads as zero and writes to it are ignored.

Top module: `frac_clk_div`

## Requirements
- R1: The active divisor, in units of 2^-FRAC_W cycles, equals the applied field value plus 2^FRAC_W. With the defaults (FRAC_W=3), a field of 0 gives 8, and `clk_en_o` is then high in every cycle.
- R2: An all-ones field (255 with DIV_W=8) gives the largest divisor, (2^DIV_W-1)+2^FRAC_W = 263, and `active_div_o` reports that value.
- R3: A write changes only the bits set in `wr_mask`. Every other register bit keeps its value, as seen on `rd_data`.
- R4: A write to the divisor field that does not set the trigger bit leaves `active_div_o` unchanged.
- R5: Writing 1 to the trigger bit (bit TRIG_BIT=31) sets it, and it reads 1 until the update is applied. Writing 0 to that bit has no effect.
- R6: The update is applied only in a cycle in which `clk_en_o` is high. From the next cycle, the trigger bit reads 0, `active_div_o` shows the new divisor and the accumulator restarts at zero.
- R7: After a switch to divisor D, the number of pulses in the first n cycles is floor(n*2^FRAC_W/D), measured from the first cycle in which the trigger bit reads 0.
- R8: When FIXED_SCALED is nonzero, the divisor field always reads 0, writes to it are ignored and `active_div_o` stays at FIXED_SCALED. The trigger bit still sets and self-clears.
- R9: After reset the register reads 0, `active_div_o` equals 2^FRAC_W and a pulse is issued every cycle.
- R10: The divisor field occupies `rd_data[DIV_SHIFT +: DIV_W]` (bits 11:4 by default) and reads back the staged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data |
| wr_mask | input | REG_W | Per-bit write enable |
| rd_data | output | REG_W | Current register contents |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| active_div_o | output | DIV_W+1 | Divisor in use, scaled by 2^FRAC_W |

## Verification
The assertions check several properties on every cycle:
- The accumulator always stays below the active divisor.
- The active divisor stays within its legal range and changes only on an apply event.
- After an apply, the trigger bit clears and the accumulator restarts.
- Register bits hold their value when no write occurs.
- A unit divisor produces a pulse in every cycle.

Some behaviours can only be shown by the bench's scenarios. These are the exact pulse counts for a given divisor over a window, the fact that a field written without the trigger has no effect, and the ignored writes in the fixed build.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned MAXW = 32;

  // Divisor in 2^-frac_w units from a stored field value (implicit +1.0).
  function automatic logic [MAXW:0] scaled_of(input logic [MAXW-1:0] field,
                                               input int unsigned frac_w);
    logic [MAXW:0] one;
    one = '0;
    one[frac_w] = 1'b1;
    return {1'b0, field} + one;
  endfunction

  // Largest scaled divisor a field of div_w bits can express.
  function automatic logic [MAXW:0] div_ceiling(input int unsigned div_w,
                                                input int unsigned frac_w);
    logic [MAXW:0] ones;
    ones = '0;
    for (int i = 0; i < int'(div_w); i++) ones[i] = 1'b1;
    return scaled_of(ones[MAXW-1:0], frac_w);
  endfunction
endpackage

// File: rtl/fdiv_ctrl_reg.sv
module fdiv_ctrl_reg #(
  parameter int REG_W        = 32,
  parameter int DIV_SHIFT    = 4,
  parameter int DIV_W        = 8,
  parameter int TRIG_BIT     = 31,
  parameter int FIXED_SCALED = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  input  logic             apply,
  output logic [REG_W-1:0] q_o,
  output logic [DIV_W-1:0] field_o
);
  localparam logic [REG_W-1:0] FIELD_MASK =
    ({REG_W{1'b1}} >> (REG_W - DIV_W)) << DIV_SHIFT;

  logic [REG_W-1:0] q, merged, nxt, keep_mask;
  logic             set_trig;

  if (FIXED_SCALED != 0) begin : g_fixed
    assign keep_mask = ~FIELD_MASK;
  end else begin : g_prog
    assign keep_mask = {REG_W{1'b1}};
  end

  assign set_trig = wr_en & wr_mask[TRIG_BIT] & wr_data[TRIG_BIT];

  always_comb begin
    merged = q;
    if (wr_en) merged = (q & ~wr_mask) | (wr_data & wr_mask);
    nxt = merged & keep_mask;
    nxt[TRIG_BIT] = set_trig | (q[TRIG_BIT] & ~apply);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign q_o     = q;
  assign field_o = q[DIV_SHIFT +: DIV_W];
endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int DW     = 9,
  parameter int FRAC_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_i,
  input  logic          restart,
  output logic          tick_o,
  output logic [DW-1:0] acc_o
);
  localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1} << FRAC_W;

  logic [DW-1:0] acc_q;
  logic [DW:0]   sum, rem;

  assign sum    = {1'b0, acc_q} + ONE;
  assign rem    = sum - {1'b0, div_i};
  assign tick_o = (sum >= {1'b0, div_i});

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (restart) acc_q <= '0;
    else if (tick_o)  acc_q <= rem[DW-1:0];
    else              acc_q <= sum[DW-1:0];
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/fdiv_active_div.sv
module fdiv_active_div #(
  parameter int DW           = 9,
  parameter int DIV_W        = 8,
  parameter int FRAC_W       = 3,
  parameter int FIXED_SCALED = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] field_i,
  output logic [DW-1:0]    div_o
);
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1} << FRAC_W;
  localparam logic [DW-1:0] RST_DIV = (FIXED_SCALED != 0) ? DW'(FIXED_SCALED) : ONE;

  logic [DW-1:0] staged, load_val, div_q;

  assign staged   = DW'(frac_div_pkg::scaled_of(32'(field_i), FRAC_W));
  assign load_val = (FIXED_SCALED != 0) ? DW'(FIXED_SCALED) : staged;

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= RST_DIV;
    else if (load) div_q <= load_val;
  end

  assign div_o = div_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int REG_W        = 32,
  parameter int DIV_SHIFT    = 4,
  parameter int DIV_W        = 8,
  parameter int FRAC_W       = 3,
  parameter int TRIG_BIT     = 31,
  parameter int FIXED_SCALED = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [REG_W-1:0]     wr_mask,
  output logic [REG_W-1:0]     rd_data,
  output logic                 clk_en_o,
  output logic [DIV_W:0]       active_div_o
);
  localparam int DW = DIV_W + 1;

  logic [REG_W-1:0] reg_q;
  logic [DIV_W-1:0] pending_field;
  logic [DW-1:0]    active_div, acc_q;
  logic             tick, apply_evt;

  // switch point: a pending trigger meets the end of an output period
  assign apply_evt = reg_q[TRIG_BIT] & tick;

  fdiv_ctrl_reg #(
    .REG_W(REG_W), .DIV_SHIFT(DIV_SHIFT), .DIV_W(DIV_W),
    .TRIG_BIT(TRIG_BIT), .FIXED_SCALED(FIXED_SCALED)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .apply(apply_evt), .q_o(reg_q), .field_o(pending_field)
  );

  fdiv_active_div #(
    .DW(DW), .DIV_W(DIV_W), .FRAC_W(FRAC_W), .FIXED_SCALED(FIXED_SCALED)
  ) act_i (
    .clk(clk), .rst_n(rst_n), .load(apply_evt), .field_i(pending_field),
    .div_o(active_div)
  );

  fdiv_phase_acc #(.DW(DW), .FRAC_W(FRAC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .div_i(active_div), .restart(apply_evt),
    .tick_o(tick), .acc_o(acc_q)
  );

  assign rd_data      = reg_q;
  assign clk_en_o     = tick;
  assign active_div_o = active_div;
endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
  parameter int REG_W        = 32,
  parameter int DIV_SHIFT    = 4,
  parameter int DIV_W        = 8,
  parameter int FRAC_W       = 3,
  parameter int TRIG_BIT     = 31,
  parameter int FIXED_SCALED = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] wr_mask,
  input logic [REG_W-1:0] rd_data,
  input logic             tick,
  input logic [DIV_W:0]   active_div,
  input logic [DIV_W:0]   acc,
  input logic             apply_evt
);
  localparam int DW = DIV_W + 1;
  localparam logic [DW-1:0]    ONE  = {{(DW-1){1'b0}}, 1'b1} << FRAC_W;
  localparam logic [DW-1:0]    MAXD = DW'(frac_div_pkg::div_ceiling(DIV_W, FRAC_W));
  localparam logic [REG_W-1:0] TMASK = {{(REG_W-1){1'b0}}, 1'b1} << TRIG_BIT;

  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div == ONE) |-> tick);

  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div >= ONE) && (active_div <= MAXD));

  assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data & ~TMASK));

  assert_no_early_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> $stable(active_div));

  assert_trig_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[TRIG_BIT] && !apply_evt) |=> rd_data[TRIG_BIT]);

  assert_trig_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_evt && !(wr_en && wr_mask[TRIG_BIT] && wr_data[TRIG_BIT])) |=> !rd_data[TRIG_BIT]);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> (acc == '0));

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc < active_div);

  if (FIXED_SCALED != 0) begin : g_fixed_chk
    assert_const_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active_div == DW'(FIXED_SCALED)) && (rd_data[DIV_SHIFT +: DIV_W] == '0));
  end
endmodule

bind frac_clk_div frac_clk_div_chk #(
  .REG_W(REG_W), .DIV_SHIFT(DIV_SHIFT), .DIV_W(DIV_W),
  .FRAC_W(FRAC_W), .TRIG_BIT(TRIG_BIT), .FIXED_SCALED(FIXED_SCALED)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .wr_mask(wr_mask), .rd_data(rd_data), .tick(clk_en_o),
  .active_div(active_div_o), .acc(acc_q), .apply_evt(apply_evt)
);

// File: tb/frac_clk_div_tb_top.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;
  localparam int NV = 6;
  localparam logic [31:0] FMASK = 32'h0000_0FF0;
  localparam logic [31:0] TMASK = 32'h8000_0000;
  localparam int VF [NV] = '{0, 8, 4, 255, 1, 20};
  localparam int VN [NV] = '{20, 20, 30, 600, 50, 70};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, f_wr_en = 1'b0;
  logic [31:0] wr_data = '0, wr_mask = '0;
  logic [31:0] rd_data, f_rd;
  logic        pulse, f_pulse;
  logic [8:0]  active, f_active;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  frac_clk_div dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_data(rd_data), .clk_en_o(pulse), .active_div_o(active)
  );

  frac_clk_div #(.FIXED_SCALED(20)) fix_i (
    .clk(clk), .rst_n(rst_n), .wr_en(f_wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .rd_data(f_rd), .clk_en_o(f_pulse), .active_div_o(f_active)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit to_fixed, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    wr_data = d; wr_mask = m;
    if (to_fixed) f_wr_en = 1'b1; else wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; f_wr_en = 1'b0;
  endtask

  task automatic wait_apply(input bit fx, output bit last_pulse);
    bit cleared = 1'b0;
    last_pulse = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (!(fx ? f_rd[31] : rd_data[31])) begin cleared = 1'b1; break; end
      last_pulse = fx ? f_pulse : pulse;
      @(negedge clk);
    end
    check("R6 trigger self-clears", cleared, 1);
  endtask

  task automatic count(input bit fx, input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      c += int'(fx ? f_pulse : pulse);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_bad++;
      $display("FAIL R7 watchdog expired actual=%0d expected=0", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit lp;
    int c;
    logic [8:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset register", rd_data, 0);
    check("R9 reset divisor", active, 8);
    check("R9 reset pulse", pulse, 1);
    check("R8 fixed reset divisor", f_active, 20);

    // vector table: stage field, trigger, verify switch point and pulse count
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, (32'(VF[i]) << 4) | TMASK, FMASK | TMASK);
      check("R5 trigger reads 1 while pending", rd_data[31], 1);
      check("R10 field readback", rd_data[11:4], VF[i]);
      wait_apply(1'b0, lp);
      check("R6 switch on pulse cycle", lp, 1);
      check("R1 active divisor", active, VF[i] + 8);
      if (VF[i] == 255) check("R2 max divisor", active, 263);
      count(1'b0, VN[i], c);
      check("R7 pulse count", c, (VN[i] * 8) / (VF[i] + 8));
    end

    // R4: field write without trigger has no effect on the divisor
    held = active;
    wr(1'b0, 32'(100) << 4, FMASK);
    repeat (40) @(negedge clk);
    check("R4 divisor unchanged", active, held);
    check("R4 trigger idle", rd_data[31], 0);
    // R5: writing 0 to trigger does nothing
    wr(1'b0, 32'h0, TMASK);
    repeat (40) @(negedge clk);
    check("R5 zero trigger write", rd_data[31], 0);
    check("R5 divisor unchanged", active, held);

    // R3: masked writes keep other bits
    wr(1'b0, 32'h0000_0005, 32'h0000_000F);
    wr(1'b0, 32'h7FFF_FFFF, FMASK);
    check("R3 low bits kept", rd_data[3:0], 5);
    check("R3 field written", rd_data[11:4], 255);
    check("R3 upper bits kept", rd_data[30:12], 0);

    // R8: fixed build ignores the field, trigger still cycles
    wr(1'b1, (32'(255) << 4) | TMASK, FMASK | TMASK);
    check("R8 fixed field reads zero", f_rd[11:4], 0);
    check("R8 fixed trigger pending", f_rd[31], 1);
    wait_apply(1'b1, lp);
    check("R8 fixed divisor kept", f_active, 20);
    count(1'b1, 40, c);
    check("R8 fixed pulse count", c, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule